// File: doc/BRIEF.md
# Event-Driven PWM Channel

This block is a single pulse-width-modulation channel whose waveform is built from counter events instead of a fixed compare-and-clear rule. A 16-bit counter, stepped by a 12-bit clock divider, runs in one of three modes: rising, falling, or rising then falling for center-aligned waveforms. Four events are decoded from that counter: reaching zero, reaching the compare value on the way up, reaching the period value, and reaching the compare value on the way down. For each event a 2-bit action code says what happens to the output: keep it, drive it low, drive it high, or flip it.

Period and compare values are written into shadow registers. They are copied into the working registers only at the boundary of a PWM cycle, so software can retune a running waveform without glitches. A stop/start pair freezes and resumes the channel. A clear strobe sends the counter back to zero. After the action logic, an inverter and a forced-level override shape the pin. Each event is also reported on its own one-cycle strobe, so a neighbouring block such as a converter trigger can use it.

Top module: `evpwm_channel`

## Requirements
- R1: After reset the channel is stopped, all registers hold zero, `pwm_out` is 0 and no event strobe is high.
- R2: A write with `wr_en` high stores `wr_data` by `wr_addr`: 0 = control (bits 1:0 count mode, bit 2 invert, bit 3 force enable, bit 4 forced level), 1 = actions (bits 1:0 zero, 3:2 compare-up, 5:4 period, 7:6 compare-down), 2 = divider (bits 11:0), 3 = period shadow, 4 = compare shadow; other addresses change nothing.
- R3: While running, the counter takes one step every divider+1 clock cycles.
- R4: Count mode 0 (up) counts 0 to PERIOD and wraps to 0, a cycle of PERIOD+1 steps; compare-up fires whenever the count arrives at COMPARE, compare-down never.
- R5: Count mode 1 (down) counts PERIOD down to 0 and then reloads PERIOD, a cycle of PERIOD+1 steps; compare-down fires whenever the count arrives at COMPARE, compare-up never.
- R6: Count mode 2 (up-down) rises 0 to PERIOD and falls back to 0, a cycle of 2*PERIOD steps; an arrival at COMPARE by an increment fires compare-up, and an arrival by a decrement fires compare-down (zero is reached by a decrement).
- R7: Action codes: 0 keeps the output, 1 drives it low, 2 drives it high, 3 inverts it; with no event the output does not change.
- R8: When several events arrive together, the highest-priority event whose code is not 0 decides, in the order period, compare-down, compare-up, zero.
- R9: Values written to the period and compare shadows take effect only when the next cycle starts: at zero in up-down mode, at the wrap in up mode, at the reload in down mode.
- R10: While the working period is 0 the counter holds still and no event fires; a nonzero period written to the shadow restarts counting.
- R11: A `cnt_clr` pulse sets the counter to 0 at the next edge without firing an event; counting resumes from 0.
- R12: `stop` halts the counter (stop wins over `start`); while halted no event fires and the output keeps its level; `start` resumes.
- R13: With invert set the pin is the action output inverted; with force enable set the pin equals the forced level regardless of everything else.
- R14: Event strobes are one clock long and rise in the same cycle as the counter arrives at the new value; the action output changes only in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| start | input | 1 | Pulse: begin or resume counting |
| stop | input | 1 | Pulse: halt counting |
| cnt_clr | input | 1 | Pulse: counter to zero |
| pwm_out | output | 1 | PWM pin |
| ev_zero | output | 1 | Strobe: counter arrived at zero |
| ev_cmp_up | output | 1 | Strobe: compare reached while rising |
| ev_period | output | 1 | Strobe: counter arrived at period |
| ev_cmp_down | output | 1 | Strobe: compare reached while falling |

## Verification
The assertions check, on every cycle, the properties that hold locally. Divider ticks never come back to back unless the divider is zero. A clear leaves a zero count and no strobe. A zero period freezes the counter. Strobes only follow a counter step. A halted channel stays quiet. A period event with a drive-high code sets the output. The output does not move without an event, and the forced level stays steady. Only the bench's scenarios can show the whole-cycle behaviour: cycle lengths and high times in each count mode, the priority corners where events coincide, the deferred effect of shadow writes, the toggle alternation, and the delay from a clear to the next zero event.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2
  } cnt_mode_e;

  localparam logic [1:0] ACT_KEEP = 2'd0;
  localparam logic [1:0] ACT_LOW  = 2'd1;
  localparam logic [1:0] ACT_HIGH = 2'd2;
  localparam logic [1:0] ACT_FLIP = 2'd3;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_ACTION = 3'd1;
  localparam logic [2:0] ADDR_DIV    = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_CMP    = 3'd4;

  typedef struct packed {
    logic [1:0] on_cmp_dn;
    logic [1:0] on_period;
    logic [1:0] on_cmp_up;
    logic [1:0] on_zero;
  } act_set_t;

  typedef struct packed {
    logic cmp_dn;
    logic period;
    logic cmp_up;
    logic zero;
  } ev_set_t;

  typedef struct packed {
    logic      mask_lvl;
    logic      mask_en;
    logic      invert;
    cnt_mode_e mode;
  } ctrl_t;

  // Choose the code of the highest-priority event that carries a non-keep code.
  function automatic logic [1:0] pick_action(ev_set_t ev, act_set_t a);
    logic [1:0] code;
    code = ACT_KEEP;
    if (ev.zero   && a.on_zero   != ACT_KEEP) code = a.on_zero;
    if (ev.cmp_up && a.on_cmp_up != ACT_KEEP) code = a.on_cmp_up;
    if (ev.cmp_dn && a.on_cmp_dn != ACT_KEEP) code = a.on_cmp_dn;
    if (ev.period && a.on_period != ACT_KEEP) code = a.on_period;
    return code;
  endfunction

  function automatic logic apply_action(logic cur, logic [1:0] code);
    case (code)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/evpwm_prescaler.sv
module evpwm_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] acc;

  assign tick = run && (acc >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (clr)     acc <= '0;
    else if (run) begin
      if (tick)       acc <= '0;
      else            acc <= acc + 1'b1;
    end
  end

  // R3: after a tick the next tick needs div further cycles
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));

endmodule

// File: rtl/evpwm_counter.sv
module evpwm_counter
  import evpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] per_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output ev_set_t          ev_nxt,
  output ev_set_t          ev_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] per_act, per_n;
  logic [CNT_W-1:0] cmp_act, cmp_n;
  logic             dir_down, dir_n;
  logic             rise, moved, load;

  always_comb begin
    cnt_n = cnt;
    per_n = per_act;
    cmp_n = cmp_act;
    dir_n = (mode == CM_UPDOWN) ? dir_down : 1'b0;
    rise  = 1'b0;
    moved = 1'b0;
    load  = 1'b0;
    if (tick && !clr) begin
      if (per_act == '0) begin
        load = 1'b1;
      end else begin
        moved = 1'b1;
        case (mode)
          CM_DOWN: begin
            if (cnt == '0) begin
              cnt_n = per_buf;
              load  = 1'b1;
            end else begin
              cnt_n = cnt - ONE;
            end
          end
          CM_UPDOWN: begin
            if (dir_n || cnt >= per_act) begin
              cnt_n = cnt - ONE;
              dir_n = (cnt_n != '0);
              load  = (cnt_n == '0);
            end else begin
              cnt_n = cnt + ONE;
              rise  = 1'b1;
              dir_n = (cnt_n >= per_act);
            end
          end
          default: begin
            rise = 1'b1;
            if (cnt >= per_act) begin
              cnt_n = '0;
              load  = 1'b1;
            end else begin
              cnt_n = cnt + ONE;
            end
          end
        endcase
      end
    end
    if (load) begin
      per_n = per_buf;
      cmp_n = cmp_buf;
    end
    ev_nxt.zero   = moved && (cnt_n == '0);
    ev_nxt.period = moved && (cnt_n == per_n);
    ev_nxt.cmp_up = moved && rise && (cnt_n == cmp_n);
    ev_nxt.cmp_dn = moved && !rise && (cnt_n == cmp_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      per_act  <= '0;
      cmp_act  <= '0;
      dir_down <= 1'b0;
      ev_q     <= '0;
    end else if (clr) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      ev_q     <= '0;
    end else begin
      cnt      <= cnt_n;
      per_act  <= per_n;
      cmp_act  <= cmp_n;
      dir_down <= dir_n;
      ev_q     <= ev_nxt;
    end
  end

  // R11: clear leaves a zero count and no strobe
  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && ev_q == '0));

  // R10: a zero working period freezes the count and fires nothing
  assert_zero_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per_act == '0 && !clr) |=> (ev_q == '0 && $stable(cnt)));

  // R14: strobes only appear right after a divider tick
  assert_strobe_follows_tick_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q != '0) |-> $past(tick));

endmodule

// File: rtl/evpwm_action.sv
module evpwm_action
  import evpwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ev_set_t  ev_in,
  input  act_set_t acts,
  output logic     level
);

  logic [1:0] code;

  assign code = pick_action(ev_in, acts);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= apply_action(level, code);
  end

  // R8: a period event coded drive-high always wins
  assert_period_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in.period && acts.on_period == ACT_HIGH) |=> level);

  // R7: without an event the output holds
  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in == '0) |=> $stable(level));

endmodule

// File: rtl/evpwm_channel.sv
module evpwm_channel
  import evpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              start,
  input  logic              stop,
  input  logic              cnt_clr,
  output logic              pwm_out,
  output logic              ev_zero,
  output logic              ev_cmp_up,
  output logic              ev_period,
  output logic              ev_cmp_down
);

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ACT_W  = $bits(act_set_t);

  ctrl_t            ctrl_q;
  act_set_t         acts_q;
  logic [PSC_W-1:0] div_q;
  logic [CNT_W-1:0] per_buf, cmp_buf;
  logic             running;
  logic             tick;
  logic             level;
  ev_set_t          ev_nxt, ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      acts_q  <= '0;
      div_q   <= '0;
      per_buf <= '0;
      cmp_buf <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(ADDR_CTRL):   ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_W'(ADDR_ACTION): acts_q  <= act_set_t'(wr_data[ACT_W-1:0]);
        ADDR_W'(ADDR_DIV):    div_q   <= wr_data[PSC_W-1:0];
        ADDR_W'(ADDR_PERIOD): per_buf <= wr_data;
        ADDR_W'(ADDR_CMP):    cmp_buf <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     running <= 1'b0;
    else if (stop)  running <= 1'b0;
    else if (start) running <= 1'b1;
  end

  evpwm_prescaler #(.PSC_W(PSC_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (running),
    .clr  (cnt_clr),
    .div  (div_q),
    .tick (tick)
  );

  evpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (cnt_clr),
    .mode   (ctrl_q.mode),
    .per_buf(per_buf),
    .cmp_buf(cmp_buf),
    .ev_nxt (ev_nxt),
    .ev_q   (ev_q)
  );

  evpwm_action u_act (
    .clk  (clk),
    .rst_n(rst_n),
    .ev_in(ev_nxt),
    .acts (acts_q),
    .level(level)
  );

  assign ev_zero     = ev_q.zero;
  assign ev_cmp_up   = ev_q.cmp_up;
  assign ev_period   = ev_q.period;
  assign ev_cmp_down = ev_q.cmp_dn;
  assign pwm_out     = ctrl_q.mask_en ? ctrl_q.mask_lvl : (level ^ ctrl_q.invert);

  // R12: a halted channel emits no strobe in the following cycle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (ev_q == '0));

  // R13: a steady forced level keeps the pin steady
  assert_forced_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mask_en && $stable(ctrl_q.mask_en) && $stable(ctrl_q.mask_lvl)) |-> $stable(pwm_out));

endmodule

// File: tb/tb_evpwm_channel.sv
`timescale 1ns/1ps
module tb_evpwm_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0, stop = 1'b0, cnt_clr = 1'b0;
  logic        pwm_out, ev_zero, ev_cmp_up, ev_period, ev_cmp_down;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evpwm_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .stop(stop), .cnt_clr(cnt_clr), .pwm_out(pwm_out),
    .ev_zero(ev_zero), .ev_cmp_up(ev_cmp_up), .ev_period(ev_period), .ev_cmp_down(ev_cmp_down)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [11:0] div;
    logic [15:0] per;
    logic [15:0] cmp;
    logic [7:0]  act;
    logic [15:0] len;
    logic [15:0] high;
  } vec_t;

  // up: zero->high, cmp-up->low (0x06); down: period->high, cmp-down->low (0x60);
  // up-down: cmp-up->high, cmp-down->low (0x48)
  localparam vec_t VECS [9] = '{
    '{2'd0, 12'd0, 16'd9, 16'd3, 8'h06, 16'd10, 16'd3},
    '{2'd0, 12'd2, 16'd4, 16'd2, 8'h06, 16'd15, 16'd6},
    '{2'd0, 12'd0, 16'd5, 16'd0, 8'h06, 16'd6,  16'd0},
    '{2'd0, 12'd0, 16'd5, 16'd7, 8'h06, 16'd6,  16'd6},
    '{2'd1, 12'd0, 16'd7, 16'd2, 8'h60, 16'd8,  16'd5},
    '{2'd1, 12'd1, 16'd7, 16'd7, 8'h60, 16'd16, 16'd16},
    '{2'd2, 12'd0, 16'd6, 16'd2, 8'h48, 16'd12, 16'd8},
    '{2'd2, 12'd3, 16'd4, 16'd1, 8'h48, 16'd32, 16'd24},
    '{2'd2, 12'd0, 16'd5, 16'd0, 8'h48, 16'd10, 16'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_zero(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (ev_zero) begin seen = 1'b1; break; end
    end
  endtask

  // Called at a negedge where ev_zero is high; returns at the next one.
  task automatic measure(output int len, output int high, output int nper, output int nglitch);
    logic prev;
    len = 0; high = 0; nper = 0; nglitch = 0;
    prev = pwm_out;
    do begin
      if (pwm_out) high++;
      if (ev_period) nper++;
      if (len > 0 && pwm_out != prev &&
          !(ev_zero || ev_cmp_up || ev_period || ev_cmp_down)) nglitch++;
      prev = pwm_out;
      len++;
      @(negedge clk);
      wr_en = 1'b0;
    end while (!ev_zero && len < 5000);
  endtask

  task automatic setup(input logic [1:0] mode, input logic [11:0] dv, input logic [15:0] per,
                       input logic [15:0] cmp, input logic [7:0] act);
    bit seen;
    pulse_stop();
    wr(3'd0, {14'd0, mode});
    wr(3'd1, {8'd0, act});
    wr(3'd2, {4'd0, dv});
    wr(3'd3, per);
    wr(3'd4, cmp);
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    pulse_start();
    for (int k = 0; k < 3; k++) begin
      wait_zero(3000, seen);
      check(seen, "R4 setup zero event", 0, 1);
    end
  endtask

  initial begin
    int len, high, nper, ng, h1, h2, k, bad;
    bit seen;
    logic held;

    // R1: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pwm_out || ev_zero || ev_cmp_up || ev_period || ev_cmp_down) bad++;
    end
    check(bad == 0, "R1 reset quiet", bad, 0);

    // Table of scenarios
    for (int v = 0; v < 9; v++) begin
      setup(VECS[v].mode, VECS[v].div, VECS[v].per, VECS[v].cmp, VECS[v].act);
      measure(len, high, nper, ng);
      case (VECS[v].mode)
        2'd0: check(len == int'(VECS[v].len), "R4 R3 up cycle length", len, VECS[v].len);
        2'd1: check(len == int'(VECS[v].len), "R5 R3 down cycle length", len, VECS[v].len);
        default: check(len == int'(VECS[v].len), "R6 R3 up-down cycle length", len, VECS[v].len);
      endcase
      check(high == int'(VECS[v].high), "R7/R8 high time", high, VECS[v].high);
      check(nper == 1, "R4 period strobes per cycle", nper, 1);
      check(ng == 0, "R14 output change without strobe", ng, 0);
    end

    // R9: shadow compare write takes effect next cycle
    setup(2'd0, 12'd0, 16'd9, 16'd3, 8'h06);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd6;
    measure(len, high, nper, ng);
    check(high == 3, "R9 current cycle keeps old compare", high, 3);
    measure(len, high, nper, ng);
    check(high == 6, "R9 next cycle uses new compare", high, 6);

    // R2: unused address changes nothing
    wr(3'd7, 16'hFFFF);
    wait_zero(100, seen);
    measure(len, high, nper, ng);
    check(high == 6 && len == 10, "R2 unused address ignored", high, 6);

    // R13: invert, then forced levels
    wr(3'd0, 16'h0004);
    wait_zero(100, seen);
    measure(len, high, nper, ng);
    check(high == 4, "R13 inverted high time", high, 4);
    wr(3'd0, 16'h001C);
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!pwm_out) bad++; end
    check(bad == 0, "R13 forced high", bad, 0);
    wr(3'd0, 16'h000C);
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out) bad++; end
    check(bad == 0, "R13 forced low", bad, 0);
    wr(3'd0, 16'h0000);

    // R12: stop holds, start resumes
    repeat (4) @(negedge clk);
    pulse_stop();
    held = pwm_out;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out != held || ev_zero || ev_cmp_up || ev_period || ev_cmp_down) bad++;
    end
    check(bad == 0, "R12 halted channel quiet", bad, 0);
    pulse_start();
    wait_zero(40, seen);
    check(seen, "R12 resume after start", seen, 1);

    // R11: clear restarts the count from zero
    repeat (3) @(negedge clk);
    cnt_clr = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      cnt_clr = 1'b0;
      k++;
    end while (!ev_zero && k < 100);
    check(k == 11, "R11 clear to next zero event", k, 11);

    // R10: zero period stops, nonzero restarts
    wr(3'd3, 16'd0);
    wait_zero(40, seen);
    held = pwm_out;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out != held || ev_zero || ev_cmp_up || ev_period || ev_cmp_down) bad++;
    end
    check(bad == 0, "R10 zero period frozen", bad, 0);
    wr(3'd3, 16'd9);
    wait_zero(40, seen);
    check(seen, "R10 restart with nonzero period", seen, 1);

    // R7: toggle action alternates per cycle
    setup(2'd0, 12'd0, 16'd3, 16'd9, 8'h03);
    measure(len, h1, nper, ng);
    measure(len, h2, nper, ng);
    check(h1 + h2 == 4 && h1 != h2, "R7 toggle alternates", h1 + h2, 4);

    finish_run();
  end

endmodule